// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management master for the serial link that reads and writes PHY registers. It produces the MDC clock and drives the MDIO line through a pad that has an output enable. Each frame has an optional run of 32 ones, then a start code, an opcode, a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits. Both the Clause 22 and the Clause 45 start codes are supported. A host loads the write data and then writes a command word. The block launches one frame and reports its progress through PENDING and VAL flags, kept separately for the read and the write direction.

The MDC half-period is set in system-clock cycles. The point at which read data is captured is also set in system-clock cycles. It is counted from one of two MDC rising edges: the edge on which the PHY launches a bit, or the next rising edge. The second choice lets the block cope with slow PHY output delays. While no frame is in flight, MDC either runs freely or is held low. Deasserting the enable stops all activity at once.

Top module: `mdio_master`

## Requirements
- R1: One MDC period is 2×`phase` system clocks. Each bit slot begins with MDC low for `phase` clocks, followed by MDC high for `phase` clocks. The master changes MDIO only at the start of a slot.
- R2: A frame is 32 ones when `preamble_en`=1 (none otherwise), then the start code (2'b01 when `c45_mode`=0, 2'b00 when `c45_mode`=1), the 2-bit opcode, the PHY address and the register address, each MSB first. A write frame then sends turnaround 1,0 and the 16 write-data bits, MSB first.
- R3: In a read frame (`cmd_op[1]`=1), `mdio_oe` is 0 during both turnaround bits and all 16 data bits. The 16 captured bits appear in `rd_data` with the first received bit as bit 15.
- R4: The data bit in body position j is captured `sample` clocks after an MDC rising edge. With `sample_late`=0 this is the rising edge of slot j-1. With `sample_late`=1 it is the rising edge of slot j.
- R5: An opcode with bit 1 set is read-type and raises `rd_pend`. Any other opcode is write-type and raises `wr_pend`. In Clause 45 mode this makes opcode 2'b10 (post-read-increment) a read.
- R6: The pending flag of a frame rises one clock after the frame is launched. With MDC held idle, the frame completes 2+2×`phase`×slots clocks after the clock edge that accepts the command, where slots is 64 with the preamble and 32 without it. At completion the pending flag drops and the VAL flag of that type sets in the same clock.
- R7: A pulse on `rd_ack` clears `rd_val`, and a pulse on `wr_ack` clears `wr_val`, one clock later.
- R8: A command written while a frame is pending or in flight is ignored.
- R9: While `en`=0, MDC stays low, `mdio_oe` stays 0 and commands are ignored. Dropping `en` abandons a frame in flight and clears both pending flags one clock later.
- R10: With `mdc_still`=1, MDC stays low while idle, and a command launches on the next clock. With `mdc_still`=0, MDC runs continuously while enabled, and a frame starts at the next slot boundary.
- R11: A pulse on `wd_wr` stores `wd_data`, and the next write frame sends that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Interface enable |
| c45_mode | input | 1 | 1 selects Clause 45 framing, 0 selects Clause 22 |
| preamble_en | input | 1 | Send 32 ones before each frame |
| mdc_still | input | 1 | Hold MDC low while idle |
| sample_late | input | 1 | Reference the sample count to the later rising edge |
| phase | input | 8 | MDC half-period in clocks |
| sample | input | 9 | Read capture delay in clocks after the reference edge |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | Frame opcode |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| wd_wr | input | 1 | Write-data load strobe |
| wd_data | input | 16 | Write data |
| rd_ack | input | 1 | Host read of the read-data word; clears rd_val |
| wr_ack | input | 1 | Host read of the write-data status; clears wr_val |
| rd_data | output | 16 | Last read result |
| rd_val | output | 1 | Read completed |
| rd_pend | output | 1 | Read in flight |
| wr_val | output | 1 | Write completed |
| wr_pend | output | 1 | Write in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO pad input |

## Verification
With `phase`=4 and MDC held idle, a command accepted at clock edge 0 completes at edge 514 when the preamble is on and at edge 258 when it is off. The bench checks that the pending flag is still high after edge 513 (257) and that VAL is set after edge 514 (258). Flag clears from the acknowledge strobes and the abort caused by `en` are due one clock after the strobe, and the bench checks them at the next falling clock edge. Frame bits are recorded at each MDC rising edge. A PHY model launches read bits with a chosen delay after the rising edge, so the two capture references give different and predictable words.

// File: rtl/mdio_pkg.sv
// Shared frame geometry and command type for the MDIO master.
// Assumes 5-bit PHY and register addresses and 16-bit data, as the link defines.
package mdio_pkg;
    localparam int PHY_AW   = 5;
    localparam int REG_AW   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_LEN  = 32;
    localparam int TA_POS   = 2 + 2 + PHY_AW + REG_AW;      // body index of first turnaround bit
    localparam int BODY_LEN = TA_POS + 2 + DATA_W;
    localparam int SLOTS    = PRE_LEN + BODY_LEN;
    localparam int SLOT_W   = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [1:0]        op;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
    } mdio_cmd_t;

    // Frame body after the preamble, MSB sent first.
    function automatic logic [BODY_LEN-1:0] build_body(input logic c45,
                                                        input mdio_cmd_t c,
                                                        input logic [DATA_W-1:0] d);
        logic [1:0] st;
        st = c45 ? 2'b00 : 2'b01;
        return {st, c.op, c.phy, c.regad, 2'b10, d};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: a counter over one bit slot of 2*phase clocks.
// MDC is low in the first half of a slot and high in the second.
// Assumes phase >= 2 and that phase is not changed while running.
module mdio_clkgen #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic [PHASE_W-1:0] phase,
    output logic               mdc_o,
    output logic               bound_next,
    output logic               rise_next
);
    localparam int CW = PHASE_W + 1;

    logic [CW-1:0] cyc, cyc_n, last_cyc;

    assign last_cyc = {phase, 1'b0} - CW'(1);

    // Next position inside the slot; parked at zero when stopped.
    always_comb begin
        if (!running)              cyc_n = '0;
        else if (cyc >= last_cyc)  cyc_n = '0;
        else                       cyc_n = cyc + CW'(1);
    end

    assign bound_next = (cyc_n == '0);
    assign rise_next  = running && (cyc_n == {1'b0, phase});

    // Slot counter and registered MDC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc   <= '0;
            mdc_o <= 1'b0;
        end else begin
            cyc   <= cyc_n;
            mdc_o <= running && (cyc_n >= {1'b0, phase});
        end
    end
endmodule

// File: rtl/mdio_framer.sv
// Frame sequencer: tracks the bit slot and shifts the frame body out MSB first.
// Preamble slots send ones; the body starts at slot PRE_LEN.
module mdio_framer
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                pre_en,
    input  logic [BODY_LEN-1:0] body,
    input  logic                step,
    output logic                bit_o,
    output logic [SLOT_W-1:0]   slot,
    output logic                last
);
    logic [BODY_LEN-1:0] sh;

    assign last  = (slot == SLOT_W'(SLOTS - 1));
    assign bit_o = (slot < SLOT_W'(PRE_LEN)) ? 1'b1 : sh[BODY_LEN-1];

    // Load a new frame or advance one slot at each slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            slot <= '0;
        end else if (load) begin
            sh   <= body;
            slot <= pre_en ? '0 : SLOT_W'(PRE_LEN);
        end else if (step && !last) begin
            slot <= slot + SLOT_W'(1);
            if (slot >= SLOT_W'(PRE_LEN))
                sh <= {sh[BODY_LEN-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdio_sampler.sv
// Read capture: each arm loads a delay; when it runs out, one MDIO bit
// is shifted into the result word. Assumes arms are further apart than the delay.
module mdio_sampler #(
    parameter int SAMPLE_W = 9,
    parameter int WORD_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                arm,
    input  logic [SAMPLE_W-1:0] delay,
    input  logic                din,
    output logic                armed,
    output logic [WORD_W-1:0]   word
);
    logic [SAMPLE_W-1:0] cnt;

    // Delay countdown and serial capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
            word  <= '0;
        end else if (clr) begin
            armed <= 1'b0;
            word  <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= delay;
        end else if (armed) begin
            if (cnt <= SAMPLE_W'(1)) begin
                armed <= 1'b0;
                word  <= {word[WORD_W-2:0], din};
            end else begin
                cnt <= cnt - SAMPLE_W'(1);
            end
        end
    end

    // A capture window must close before the next one opens.
    assert_no_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !armed);
endmodule

// File: rtl/mdio_master.sv
// MDIO management master top. Accepts a command word and launches a read or
// write frame. Drives MDC and MDIO with an output enable, and captures read
// data at a programmable delay. Assumes a legal configuration:
// 1 < sample, sample + 3 <= 2*phase, preamble on in Clause 45 mode, and
// configuration held stable while a frame is in flight.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int PHASE_W  = 8,
    parameter int SAMPLE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                c45_mode,
    input  logic                preamble_en,
    input  logic                mdc_still,
    input  logic                sample_late,
    input  logic [PHASE_W-1:0]  phase,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                cmd_wr,
    input  logic [1:0]          cmd_op,
    input  logic [PHY_AW-1:0]   cmd_phy,
    input  logic [REG_AW-1:0]   cmd_reg,
    input  logic                wd_wr,
    input  logic [DATA_W-1:0]   wd_data,
    input  logic                rd_ack,
    input  logic                wr_ack,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_val,
    output logic                rd_pend,
    output logic                wr_val,
    output logic                wr_pend,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    localparam logic [SLOT_W-1:0] RELEASE_SLOT = SLOT_W'(PRE_LEN + TA_POS);
    localparam logic [SLOT_W-1:0] DATA_SLOT    = SLOT_W'(PRE_LEN + TA_POS + 2);

    mdio_cmd_t           cmd_q;
    logic [DATA_W-1:0]   wd_q;
    logic                go, busy, tail, is_read;
    logic                running, bound_next, rise_next;
    logic                launch, step, done, arm, armed;
    logic                frame_bit, last;
    logic [SLOT_W-1:0]   slot, arm_lo;
    logic [DATA_W-1:0]   cap_word;

    assign running = en && (busy || !mdc_still);
    assign launch  = en && go && !busy && bound_next;
    assign step    = busy && !tail && bound_next;
    assign done    = busy && tail && !armed;
    assign arm_lo  = sample_late ? DATA_SLOT : DATA_SLOT - SLOT_W'(1);
    assign arm     = busy && !tail && is_read && rise_next &&
                     (slot >= arm_lo) && (slot < arm_lo + SLOT_W'(DATA_W));

    assign mdio_oe = busy && !tail && !(is_read && slot >= RELEASE_SLOT);
    assign mdio_o  = mdio_oe ? frame_bit : 1'b1;

    mdio_clkgen #(.PHASE_W(PHASE_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .running(running), .phase(phase),
        .mdc_o(mdc), .bound_next(bound_next), .rise_next(rise_next)
    );

    mdio_framer u_frm (
        .clk(clk), .rst_n(rst_n), .load(launch), .pre_en(preamble_en),
        .body(build_body(c45_mode, cmd_q, wd_q)), .step(step),
        .bit_o(frame_bit), .slot(slot), .last(last)
    );

    mdio_sampler #(.SAMPLE_W(SAMPLE_W), .WORD_W(DATA_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .clr(launch || !en), .arm(arm),
        .delay(sample), .din(mdio_i), .armed(armed), .word(cap_word)
    );

    // Write-data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     wd_q <= '0;
        else if (wd_wr) wd_q <= wd_data;
    end

    // Command acceptance, frame lifetime and pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            go      <= 1'b0;
            busy    <= 1'b0;
            tail    <= 1'b0;
            is_read <= 1'b0;
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else if (!en) begin
            go      <= 1'b0;
            busy    <= 1'b0;
            tail    <= 1'b0;
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (cmd_wr && !go && !busy) begin
                cmd_q <= '{op: cmd_op, phy: cmd_phy, regad: cmd_reg};
                go    <= 1'b1;
            end
            if (launch) begin
                go      <= 1'b0;
                busy    <= 1'b1;
                tail    <= 1'b0;
                is_read <= cmd_q.op[1];
                rd_pend <= cmd_q.op[1];
                wr_pend <= !cmd_q.op[1];
            end else if (done) begin
                busy    <= 1'b0;
                tail    <= 1'b0;
                rd_pend <= 1'b0;
                wr_pend <= 1'b0;
            end else if (step && last) begin
                tail <= 1'b1;
            end
        end
    end

    // Completion flags, cleared by host acknowledge; completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_val  <= 1'b0;
            wr_val  <= 1'b0;
            rd_data <= '0;
        end else begin
            if (done && is_read) begin
                rd_val  <= 1'b1;
                rd_data <= cap_word;
            end else if (rd_ack) begin
                rd_val <= 1'b0;
            end
            if (done && !is_read)  wr_val <= 1'b1;
            else if (wr_ack)       wr_val <= 1'b0;
        end
    end

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!mdc && !mdio_oe && !rd_pend && !wr_pend));
    assert_one_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pend && wr_pend));
    assert_rdval_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_val) |-> $past(rd_pend));
    assert_wrval_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_val) |-> $past(wr_pend));
    assert_launch_from_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 4;
    localparam int SMP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, c45_mode = 1'b0, preamble_en = 1'b1, mdc_still = 1'b1, sample_late = 1'b0;
    logic [7:0] phase = 8'(PH);
    logic [8:0] sample = 9'(SMP);
    logic cmd_wr = 1'b0, wd_wr = 1'b0, rd_ack = 1'b0, wr_ack = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [4:0] cmd_phy = '0, cmd_reg = '0;
    logic [15:0] wd_data = '0;
    logic [15:0] rd_data;
    logic rd_val, rd_pend, wr_val, wr_pend, mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int total = 0, bad = 0;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .en(en), .c45_mode(c45_mode), .preamble_en(preamble_en),
        .mdc_still(mdc_still), .sample_late(sample_late), .phase(phase), .sample(sample),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .wd_wr(wd_wr), .wd_data(wd_data), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .rd_data(rd_data), .rd_val(rd_val), .rd_pend(rd_pend), .wr_val(wr_val),
        .wr_pend(wr_pend), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model and frame recorder, working on the falling clock edge.
    logic phy_on = 1'b0;
    logic [15:0] phy_word = '0;
    int phy_dly = 0;
    logic mdc_d = 1'b0, oe_d = 1'b0;
    int slot_ctr = 99, since = 0;
    logic sched = 1'b0, nxt = 1'b1;
    logic rec_bit [64];
    logic rec_oe [64];

    function automatic logic phy_bit(input int s);
        int b;
        b = s - 32;
        if (!phy_on) return 1'b1;
        if (b == 15) return 1'b0;
        if (b >= 16 && b <= 31) return phy_word[31 - b];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (mdio_oe && !oe_d) begin
            slot_ctr = preamble_en ? 0 : 32;
            for (int i = 0; i < 64; i++) begin rec_bit[i] = 1'b0; rec_oe[i] = 1'b0; end
        end
        if (mdc && !mdc_d) begin
            if (slot_ctr < 64) begin
                rec_bit[slot_ctr] = mdio_o;
                rec_oe[slot_ctr]  = mdio_oe;
                nxt   = phy_bit(slot_ctr + 1);
                sched = 1'b1;
                slot_ctr = slot_ctr + 1;
            end
            since = 0;
        end else begin
            since = since + 1;
        end
        if (sched && since == phy_dly) begin
            mdio_i = nxt;
            sched  = 1'b0;
        end
        mdc_d = mdc;
        oe_d  = mdio_oe;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
        @(negedge clk);
        cmd_op = op; cmd_phy = phy; cmd_reg = rg; cmd_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic load_wd(input logic [15:0] d);
        @(negedge clk);
        wd_data = d; wd_wr = 1'b1;
        @(negedge clk);
        wd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        while ((rd_pend || wr_pend) && n < 5000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] body_got();
        logic [31:0] g;
        for (int i = 0; i < 32; i++) g[31 - i] = rec_bit[32 + i];
        return g;
    endfunction

    // Exact completion timing with MDC held idle: edge 0 accepts the command.
    task automatic timed_done(input int slots, input logic rd);
        int due;
        due = 2 + 2 * PH * slots;
        repeat (due - 1) @(posedge clk);
        @(negedge clk);
        chk((rd ? rd_pend : wr_pend) == 1'b1, "R6 pending before due edge", 32'(rd ? rd_pend : wr_pend), 1);
        chk((rd ? rd_val : wr_val) == 1'b0, "R6 val before due edge", 32'(rd ? rd_val : wr_val), 0);
        @(posedge clk);
        @(negedge clk);
        chk((rd ? rd_val : wr_val) == 1'b1, "R6 val at due edge", 32'(rd ? rd_val : wr_val), 1);
        chk((rd ? rd_pend : wr_pend) == 1'b0, "R6 pending cleared", 32'(rd ? rd_pend : wr_pend), 0);
    endtask

    task automatic t_reset();
        chk(!mdc && !mdio_oe, "R9 reset outputs quiet", {mdc, mdio_oe}, 0);
        chk({rd_val, rd_pend, wr_val, wr_pend} == 4'b0, "R6 reset flags", {rd_val, rd_pend, wr_val, wr_pend}, 0);
        chk(rd_data == 16'h0, "R3 reset rd_data", rd_data, 0);
    endtask

    task automatic t_still_idle();
        int rises;
        logic prev;
        en = 1'b1; mdc_still = 1'b1;
        rises = 0; prev = mdc;
        repeat (64) begin @(negedge clk); if (mdc && !prev) rises++; prev = mdc; end
        chk(rises == 0, "R10 MDC held while idle", rises, 0);
    endtask

    task automatic t_period();
        int hi, lo, rises;
        logic prev;
        mdc_still = 1'b0;
        @(negedge clk);
        while (mdc) @(negedge clk);
        while (!mdc) @(negedge clk);
        hi = 0; while (mdc) begin hi++; @(negedge clk); end
        lo = 0; while (!mdc) begin lo++; @(negedge clk); end
        chk(hi == PH, "R1 MDC high time", hi, PH);
        chk(lo == PH, "R1 MDC low time", lo, PH);
        rises = 0; prev = mdc;
        repeat (64) begin @(negedge clk); if (mdc && !prev) rises++; prev = mdc; end
        chk(rises == 64 / (2 * PH), "R10 MDC free-runs while idle", rises, 64 / (2 * PH));
        mdc_still = 1'b1;
        repeat (2 * PH) @(negedge clk);
    endtask

    task automatic t_write_pre();
        logic [31:0] exp;
        int ones;
        preamble_en = 1'b1; c45_mode = 1'b0; phy_on = 1'b0;
        load_wd(16'hA5C3);
        issue(2'b01, 5'h13, 5'h0A);
        timed_done(64, 1'b0);
        ones = 0;
        for (int i = 0; i < 32; i++) if (rec_bit[i] && rec_oe[i]) ones++;
        chk(ones == 32, "R2 preamble of ones", ones, 32);
        exp = {2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3};
        chk(body_got() == exp, "R2 write frame body", body_got(), exp);
        chk(rec_oe[63] == 1'b1, "R2 master drives write data", rec_oe[63], 1);
        @(negedge clk); wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
        chk(wr_val == 1'b0, "R7 wr_ack clears wr_val", wr_val, 0);
    endtask

    task automatic t_write_nopre();
        logic [31:0] exp;
        preamble_en = 1'b0;
        load_wd(16'h1E7B);
        issue(2'b01, 5'h01, 5'h1F);
        timed_done(32, 1'b0);
        exp = {2'b01, 2'b01, 5'h01, 5'h1F, 2'b10, 16'h1E7B};
        chk(body_got() == exp, "R11 new write data sent, R2 no preamble", body_got(), exp);
        wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
        preamble_en = 1'b1;
    endtask

    task automatic t_read(input logic late, input int dly, input logic [15:0] w,
                          input logic [15:0] expw, input string tag);
        sample_late = late; phy_dly = dly; phy_word = w; phy_on = 1'b1;
        issue(2'b10, 5'h07, 5'h03);
        timed_done(64, 1'b1);
        chk(rd_data == expw, tag, rd_data, expw);
        chk(rec_oe[45] == 1'b1 && rec_oe[46] == 1'b0 && rec_oe[47] == 1'b0 && rec_oe[63] == 1'b0,
            "R3 oe released in turnaround and data", {rec_oe[45], rec_oe[46], rec_oe[47], rec_oe[63]}, 4'b1000);
        @(negedge clk); rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
        chk(rd_val == 1'b0, "R7 rd_ack clears rd_val", rd_val, 0);
        phy_on = 1'b0; sample_late = 1'b0;
    endtask

    task automatic t_c45_incr();
        logic [13:0] exp;
        logic [13:0] got;
        c45_mode = 1'b1; preamble_en = 1'b1; mdc_still = 1'b0;
        phy_dly = 0; phy_word = 16'h8001; phy_on = 1'b1;
        issue(2'b10, 5'h1A, 5'h05);
        repeat (2 * PH + 2) @(negedge clk);
        chk(rd_pend == 1'b1 && wr_pend == 1'b0, "R5 post-read-increment is a read", {rd_pend, wr_pend}, 2'b10);
        wait_idle();
        for (int i = 0; i < 14; i++) got[13 - i] = rec_bit[32 + i];
        exp = {2'b00, 2'b10, 5'h1A, 5'h05};
        chk(got == exp, "R2 Clause 45 header start 00", got, exp);
        chk(rd_val == 1'b1 && rd_data == 16'h8001, "R10 free-running read completes", rd_data, 16'h8001);
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
        phy_on = 1'b0; c45_mode = 1'b0; mdc_still = 1'b1;
    endtask

    task automatic t_busy_ignore();
        int seen;
        load_wd(16'h0F0F);
        issue(2'b01, 5'h02, 5'h02);
        repeat (40) @(negedge clk);
        issue(2'b10, 5'h03, 5'h03);
        wait_idle();
        seen = 0;
        repeat (40) begin @(negedge clk); if (rd_pend || mdio_oe) seen++; end
        chk(seen == 0 && rd_val == 1'b0, "R8 command during frame ignored", seen, 0);
        chk(wr_val == 1'b1, "R8 first frame completed", wr_val, 1);
        wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
    endtask

    task automatic t_disable();
        int act;
        logic prev;
        issue(2'b01, 5'h04, 5'h04);
        repeat (100) @(negedge clk);
        chk(wr_pend == 1'b1, "R9 frame in flight before disable", wr_pend, 1);
        en = 1'b0;
        @(negedge clk);
        chk(!wr_pend && !mdio_oe && !mdc, "R9 disable abandons frame", {wr_pend, mdio_oe, mdc}, 0);
        issue(2'b10, 5'h05, 5'h05);
        act = 0; prev = mdc;
        repeat (60) begin @(negedge clk); if ((mdc && !prev) || rd_pend || mdio_oe) act++; prev = mdc; end
        chk(act == 0, "R9 no activity while disabled", act, 0);
        en = 1'b1;
        repeat (60) @(negedge clk);
        chk(!rd_pend && !wr_val, "R9 command while disabled was dropped", {rd_pend, wr_val}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_still_idle();
        t_period();
        t_write_pre();
        t_write_nopre();
        t_read(1'b0, 0, 16'h3C96, 16'h3C96, "R4 early reference, fast PHY, R3 data");
        t_read(1'b1, 5, 16'hC35A, 16'hC35A, "R4 late reference, slow PHY");
        t_read(1'b0, 5, 16'hC35A, {1'b0, 15'h61AD}, "R4 early reference sees previous bit");
        t_c45_incr();
        t_busy_ignore();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule